// File: doc/BRIEF.md
# Wait-and-See Switch Debouncer

This block turns the raw level from a mechanical push-button into clean events. The contact is wired active low, so a closed switch reads as logic 0. Contact bounce can last for several milliseconds, and a downstream edge-triggered interrupt would otherwise see several events for a single press.

The block first passes the raw line through a synchronizer chain. When the synchronized line falls, the block starts a fixed settle delay and ignores the line until that delay ends. It then rechecks the line. If the line is still low, it emits a one-cycle press pulse and raises a debounced level. If the line has gone high again, it returns to idle with no event.

A release must also be confirmed. After the line goes high, a second full delay runs before the block re-arms. The delay length is `DELAY_TICKS * TICK_DIV` clock cycles. `TICK_DIV` is a prescaler that sets the timebase. The defaults (10000 × 1) give about 10 ms at a 1 MHz clock.

The state machine has four states:
- `ST_IDLE`: armed and waiting.
- `ST_SETTLE`: press delay running.
- `ST_HELD`: press confirmed.
- `ST_RELEASE`: release delay running.

It has six transitions:
- IDLE→SETTLE on a synchronized falling edge. The timer starts.
- SETTLE→HELD when the timer is done and the line is low. The press pulse is emitted.
- SETTLE→IDLE when the timer is done and the line is high. This is a rejected glitch.
- HELD→RELEASE when the line reads high. The timer starts.
- RELEASE→IDLE when the timer is done and the line is high.
- RELEASE→HELD when the timer is done and the line is low. The release is not confirmed and no pulse is emitted.

Top module: `switch_settle`

## Requirements
- R1: While reset is asserted, and afterwards with the line held high, both `press_pulse` and `pressed_lvl` are 0.
- R2: Count the first rising edge that samples `sw_raw_n` low as edge 1. From idle, a press that is confirmed drives `press_pulse` high for exactly the cycle after edge `SYNC_STAGES+1+DELAY_TICKS*TICK_DIV`, and for no other cycle.
- R3: Toggles of `sw_raw_n` during the settle delay are ignored. One press gives exactly one pulse, timed from the first falling edge.
- R4: The recheck uses the raw value sampled at edge `DELAY_TICKS*TICK_DIV+1`. If that value is 1 (high), no pulse is emitted and the block returns to idle, ready for a later press.
- R5: `pressed_lvl` rises in the same cycle as the press pulse and stays 1 while the switch is held.
- R6: Count the first edge that samples the line high while held as edge 1. On a release, `pressed_lvl` falls in the cycle after edge `SYNC_STAGES+1+DELAY_TICKS*TICK_DIV`. Bounces during the release delay are ignored, and no pulse is emitted.
- R7: If the line reads low when the release delay ends, the block goes back to the held state. `pressed_lvl` stays 1, no pulse is emitted, and a new high level is needed to release.
- R8: While the press is held, `press_pulse` stays 0.
- R9: The settle delay is exactly `DELAY_TICKS` prescaler ticks of `TICK_DIV` clock cycles each. The pulse threshold moves with both parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_raw_n | input | 1 | Raw switch line, low when closed, asynchronous to clk |
| press_pulse | output | 1 | One-cycle pulse per confirmed press |
| pressed_lvl | output | 1 | Debounced pressed level |

## Verification
The bound checker watches several rules on every cycle:
- a pulse lasts one cycle;
- a pulse only follows the settle state, and comes with the level high;
- a high line at the recheck gives no pulse and returns the block to idle;
- the level only falls out of the release state;
- a low line at the end of the release delay brings the block back to held.

Only the bench scenarios can show the exact latency in cycles, the recheck threshold, and immunity to specific bounce patterns. To do this, the bench sweeps the glitch length across the threshold and scripts bounces during both delays.

// File: rtl/settle_pkg.sv
package settle_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_HELD    = 2'd2,
        ST_RELEASE = 2'd3
    } settle_state_e;
endpackage

// File: rtl/sw_input_stage.sv
module sw_input_stage #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic sync_n,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= raw_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], raw_n};
            end
        end
    endgenerate

    assign sync_n = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_n;
    end

    assign fall = prev_q & ~sync_n;
endmodule

// File: rtl/settle_tick_gen.sv
module settle_tick_gen #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic tick
);
    localparam int            PW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick = en && (pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pre_q <= '0;
        else if (clear || tick)  pre_q <= '0;
        else if (en)             pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int DELAY_TICKS = 10000,
    parameter int TICK_DIV    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int            CW       = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(DELAY_TICKS - 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;
    logic          tick;

    settle_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .en    (run_q),
        .tick  (tick)
    );

    assign done = tick && (cnt_q == LAST_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (done) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/switch_settle.sv
module switch_settle
    import settle_pkg::*;
#(
    parameter int DELAY_TICKS = 10000,
    parameter int TICK_DIV    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_raw_n,
    output logic press_pulse,
    output logic pressed_lvl
);
    settle_state_e state_q, state_d;
    logic          sync_n;
    logic          fall;
    logic          tmr_start;
    logic          tmr_done;

    sw_input_stage #(.STAGES(SYNC_STAGES)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (sw_raw_n),
        .sync_n (sync_n),
        .fall   (fall)
    );

    settle_timer #(.DELAY_TICKS(DELAY_TICKS), .TICK_DIV(TICK_DIV)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and timer launch
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) begin
                    state_d   = ST_SETTLE;
                    tmr_start = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_done) state_d = sync_n ? ST_IDLE : ST_HELD;
            end
            ST_HELD: begin
                if (sync_n) begin
                    state_d   = ST_RELEASE;
                    tmr_start = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (tmr_done) state_d = sync_n ? ST_IDLE : ST_HELD;
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            press_pulse <= 1'b0;
            pressed_lvl <= 1'b0;
        end else begin
            press_pulse <= (state_q == ST_SETTLE) && (state_d == ST_HELD);
            pressed_lvl <= (state_d == ST_HELD) || (state_d == ST_RELEASE);
        end
    end
endmodule

// File: rtl/switch_settle_chk.sv
module switch_settle_chk
    import settle_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input settle_state_e state,
    input logic          sync_n,
    input logic          tmr_done,
    input logic          press_pulse,
    input logic          pressed_lvl
);
    a_r2_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |=> !press_pulse);

    a_r2_pulse_from_settle: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |-> ($past(state) == ST_SETTLE) && (state == ST_HELD));

    a_r5_level_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |-> pressed_lvl);

    a_r4_high_recheck_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && tmr_done && sync_n) |=> (!press_pulse && state == ST_IDLE));

    a_r6_level_falls_from_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pressed_lvl) |-> ($past(state) == ST_RELEASE) && (state == ST_IDLE));

    a_r7_low_after_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE && tmr_done && !sync_n) |=> (state == ST_HELD && pressed_lvl && !press_pulse));

    a_r8_no_pulse_outside_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SETTLE) |=> !press_pulse);

    a_r9_done_only_when_timing: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> (state == ST_SETTLE || state == ST_RELEASE));
endmodule

bind switch_settle switch_settle_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .sync_n      (sync_n),
    .tmr_done    (tmr_done),
    .press_pulse (press_pulse),
    .pressed_lvl (pressed_lvl)
);

// File: tb/switch_settle_tb.sv
module switch_settle_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int D   = 6;
    localparam int P   = 2;
    localparam int S   = 2;
    localparam int DP  = D * P;
    localparam int LAT = S + 1 + DP;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic sw_n  = 1'b1;
    logic pulse;
    logic lvl;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    switch_settle #(.DELAY_TICKS(D), .TICK_DIV(P), .SYNC_STAGES(S)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_raw_n    (sw_n),
        .press_pulse (pulse),
        .pressed_lvl (lvl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        int first;

        // R1: reset state
        step(3);
        chk("R1 pulse in reset", int'(pulse), 0);
        chk("R1 level in reset", int'(lvl), 0);
        rst_n = 1'b1;
        step(5);
        chk("R1 pulse after reset", int'(pulse), 0);
        chk("R1 level after reset", int'(lvl), 0);

        // R2 / R5 / R8: clean press, exact latency
        @(negedge clk); sw_n = 1'b0;
        step(LAT - 1);
        chk("R2 no pulse before latency", int'(pulse), 0);
        chk("R5 level low before latency", int'(lvl), 0);
        step(1);
        chk("R2 pulse at latency", int'(pulse), 1);
        chk("R5 level rises with pulse", int'(lvl), 1);
        step(1);
        chk("R2 pulse one cycle wide", int'(pulse), 0);
        chk("R5 level held", int'(lvl), 1);
        cnt = 0;
        for (int c = 0; c < 20; c++) begin
            step(1);
            cnt += int'(pulse);
        end
        chk("R8 no pulse while held", cnt, 0);
        chk("R5 level still held", int'(lvl), 1);

        // R6: release with bounce inside release delay
        @(negedge clk); sw_n = 1'b1;
        cnt = 0;
        for (int c = 1; c <= LAT + 2; c++) begin
            @(negedge clk);
            cnt += int'(pulse);
            if (c == LAT - 1) chk("R6 level before release latency", int'(lvl), 1);
            if (c == LAT)     chk("R6 level drops at latency", int'(lvl), 0);
            if (c == 4) sw_n = 1'b0;
            if (c == 5) sw_n = 1'b1;
        end
        chk("R6 no pulse on release", cnt, 0);

        // R3: bouncing press gives one pulse
        @(negedge clk); sw_n = 1'b0;
        cnt = 0; first = -1;
        for (int c = 1; c <= LAT + 10; c++) begin
            @(negedge clk);
            if (pulse) begin
                cnt++;
                if (first < 0) first = c;
            end
            if (c == 2) sw_n = 1'b1;
            if (c == 3) sw_n = 1'b0;
            if (c == 5) sw_n = 1'b1;
            if (c == 7) sw_n = 1'b0;
        end
        chk("R3 single pulse despite bounce", cnt, 1);
        chk("R3 pulse timed from first fall", first, LAT);
        @(negedge clk); sw_n = 1'b1;
        step(LAT + 3);
        chk("R6 level low after release", int'(lvl), 0);

        // R7: line low again at end of release delay
        @(negedge clk); sw_n = 1'b0;
        step(LAT + 2);
        chk("R7 level high before test", int'(lvl), 1);
        @(negedge clk); sw_n = 1'b1;
        cnt = 0;
        for (int c = 1; c <= LAT + 6; c++) begin
            @(negedge clk);
            cnt += int'(pulse);
            if (c == LAT)     chk("R7 level kept at release end", int'(lvl), 1);
            if (c == LAT + 6) chk("R7 level still kept", int'(lvl), 1);
            if (c == 3) sw_n = 1'b0;
        end
        chk("R7 no pulse on re-entry", cnt, 0);
        @(negedge clk); sw_n = 1'b1;
        step(LAT + 3);
        chk("R7 release after new high", int'(lvl), 0);

        // R4 / R9: sweep low-time across the recheck threshold
        for (int g = 1; g <= LAT + 5; g++) begin
            int exp_cnt;
            exp_cnt = (g >= DP + 1) ? 1 : 0;
            @(negedge clk); sw_n = 1'b0;
            cnt = 0; first = -1;
            for (int c = 1; c <= g + 2*LAT + 6; c++) begin
                @(negedge clk);
                if (pulse) begin
                    cnt++;
                    if (first < 0) first = c;
                end
                if (c == g) sw_n = 1'b1;
            end
            chk($sformatf("R4 R9 pulse count for low-time %0d", g), cnt, exp_cnt);
            if (exp_cnt == 1)
                chk($sformatf("R9 pulse offset for low-time %0d", g), first, LAT);
            chk($sformatf("R4 idle level after low-time %0d", g), int'(lvl), 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule